// File: doc/BRIEF.md
# Two-Phase Transition-Signalled Pipeline Controller

This block is the control chain for an elastic pipeline of `N_STAGES` stages that use transition signalling. A request or an acknowledge is an event: a toggle of a wire, and a rising toggle counts the same as a falling one. Each stage holds one Muller C-element. The C-element's inputs are the incoming request and the inverse of the downstream stage's C-element output. The element's output is the acknowledge sent upstream and also the request sent downstream.

A stage stays locked while the request it forwarded has not been acknowledged. While locked it passes nothing further, whatever its upstream request does. When the downstream acknowledge arrives, the stage releases, and a request that is already waiting moves on at the next edge. Each stage gives a one-cycle capture enable for its data register. The control chain itself holds the pipeline occupancy, and the block reports it as one bit per stage plus empty and full flags.

The C-element is modelled with clocked state so the chain can be simulated and tested. Every C-element output is set to a known level by an asynchronous active-low reset.

Top module: `tsig_pipe_ctrl`

## Requirements
- R1: While reset is asserted, and at the first clock edge after release, every stage state equals `INIT_LEVEL`. With `dn_ack` also at `INIT_LEVEL`: `up_ack` and `dn_req` equal `INIT_LEVEL`, `occ` is all zeros, `empty` is 1, `full` is 0 and `cap_en` is all zeros.
- R2: At a clock edge, a stage's state takes the common value of its two C-element inputs (its request, and the inverse of its downstream acknowledge) when they agree. Otherwise it keeps its value.
- R3: A single toggle of `up_req` into an empty chain reaches `dn_req` after `N_STAGES` clock edges, with each stage toggling one edge after the stage before it. Rising and falling toggles behave the same way.
- R4: `up_ack` is stage 0's state. It toggles at the first edge after an `up_req` toggle when stage 0 is not locked.
- R5: A stage whose state differs from the state of the stage after it is locked. It does not toggle, whatever its request input does.
- R6: When the downstream acknowledge toggles and releases a locked stage that has a request waiting, that stage toggles at the next edge.
- R7: `cap_en[i]` is 1 in exactly those cycles whose closing edge toggles stage i's state.
- R8: `occ[i]` is 1 when stage i's state differs from its downstream acknowledge. That acknowledge is stage i+1's state, or `dn_ack` for the last stage. `empty` is the AND of all inverted `occ` bits, and `full` is the AND of all `occ` bits.
- R9: With `dn_ack` held, `N_STAGES` request toggles fill the chain. The stage states then alternate, `full` is 1, and `up_ack` no longer follows further `up_req` toggles.
- R10: Two neighbouring stages never toggle on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the C-element state model |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Request from the producer; every toggle is an event |
| up_ack | output | 1 | Acknowledge to the producer (stage 0 state) |
| dn_req | output | 1 | Request to the consumer (last stage state) |
| dn_ack | input | 1 | Acknowledge from the consumer; every toggle is an event |
| cap_en | output | N_STAGES | Per-stage one-cycle data capture enable |
| occ | output | N_STAGES | Per-stage occupancy bit |
| empty | output | 1 | No stage holds a token |
| full | output | 1 | Every stage holds a token |

## Verification
The main instance uses four stages and reset level 0. With four stages there is room for two tokens in flight at once, a chain that fills completely, a producer event that waits at a locked stage, and a release that ripples back from the consumer toggle to the head of the chain. A second instance uses two stages and reset level 1. It starts at the opposite level, so the first event is a falling toggle, and it tests the shortest chain that still has an interior neighbour boundary.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

  // Clocked Muller C-element: follow the inputs when they agree, else hold.
  function automatic logic celem_next(input logic in_a, input logic in_b,
                                      input logic cur);
    return (in_a == in_b) ? in_a : cur;
  endfunction

  // A stage holds a token while its state and its downstream acknowledge differ.
  function automatic logic token_held(input logic st, input logic ack_level);
    return st ^ ack_level;
  endfunction

endpackage

// File: rtl/tsp_stage.sv
module tsp_stage #(
  parameter bit INIT_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic ack_i,
  output logic state_o,
  output logic fire_o
);
  import tsp_pkg::*;

  logic st_q;
  logic st_nxt;

  always_comb begin
    st_nxt = celem_next(req_i, ~ack_i, st_q);
    fire_o = (st_nxt != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= INIT_LEVEL;
    else        st_q <= st_nxt;
  end

  assign state_o = st_q;
endmodule

// File: rtl/tsp_occupancy.sv
module tsp_occupancy #(
  parameter int N_STAGES = 4
) (
  input  logic [N_STAGES-1:0] st,
  input  logic [N_STAGES-1:0] ack_lvl,
  output logic [N_STAGES-1:0] occ,
  output logic                empty,
  output logic                full
);
  import tsp_pkg::*;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_occ
    assign occ[i] = token_held(st[i], ack_lvl[i]);
  end

  assign empty = ~|occ;
  assign full  = &occ;
endmodule

// File: rtl/tsig_pipe_ctrl.sv
module tsig_pipe_ctrl #(
  parameter int N_STAGES   = 4,
  parameter bit INIT_LEVEL = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                up_req,
  output logic                up_ack,
  output logic                dn_req,
  input  logic                dn_ack,
  output logic [N_STAGES-1:0] cap_en,
  output logic [N_STAGES-1:0] occ,
  output logic                empty,
  output logic                full
);
  localparam int LAST = N_STAGES - 1;

  // Named internal events, brought out for the checker.
  logic [N_STAGES-1:0] st_q;    // C-element outputs
  logic [N_STAGES-1:0] req_w;   // request input of each stage
  logic [N_STAGES-1:0] ack_w;   // downstream acknowledge level of each stage
  logic [N_STAGES-1:0] ackn_w;  // inverted acknowledge: second C-element input

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign req_w[i] = up_req;
    end else begin : g_body
      assign req_w[i] = st_q[i-1];
    end

    if (i == LAST) begin : g_tail
      assign ack_w[i] = dn_ack;
    end else begin : g_link
      assign ack_w[i] = st_q[i+1];
    end

    assign ackn_w[i] = ~ack_w[i];

    tsp_stage #(.INIT_LEVEL(INIT_LEVEL)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_w[i]),
      .ack_i  (ack_w[i]),
      .state_o(st_q[i]),
      .fire_o (cap_en[i])
    );
  end

  tsp_occupancy #(.N_STAGES(N_STAGES)) u_occ (
    .st     (st_q),
    .ack_lvl(ack_w),
    .occ    (occ),
    .empty  (empty),
    .full   (full)
  );

  assign up_ack = st_q[0];
  assign dn_req = st_q[LAST];
endmodule

// File: rtl/tsp_pipe_chk.sv
module tsp_pipe_chk #(
  parameter int N_STAGES   = 4,
  parameter bit INIT_LEVEL = 1'b0
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_STAGES-1:0] st_q,
  input logic [N_STAGES-1:0] req_w,
  input logic [N_STAGES-1:0] ackn_w,
  input logic [N_STAGES-1:0] cap_en,
  input logic                up_ack,
  input logic                full,
  input logic                empty
);
  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(rst_n) |-> (st_q == {N_STAGES{INIT_LEVEL}})); // R1

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R8

  AST_FULL_LOCKS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(up_ack)); // R9

  for (genvar i = 0; i < N_STAGES; i++) begin : g_chk
    AST_HOLD_ON_DISAGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_w[i] != ackn_w[i]) |=> $stable(st_q[i])); // R2

    AST_TAKE_ON_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_w[i] == ackn_w[i]) |=> (st_q[i] == $past(req_w[i]))); // R2

    AST_CAPTURE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en[i] |=> (st_q[i] != $past(st_q[i]))); // R7

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en[i] |=> $stable(st_q[i])); // R7

    if (i < N_STAGES - 1) begin : g_adj
      AST_NO_ADJACENT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_en[i] && cap_en[i+1])); // R10
    end
  end
endmodule

bind tsig_pipe_ctrl tsp_pipe_chk #(
  .N_STAGES  (N_STAGES),
  .INIT_LEVEL(INIT_LEVEL)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .st_q  (st_q),
  .req_w (req_w),
  .ackn_w(ackn_w),
  .cap_en(cap_en),
  .up_ack(up_ack),
  .full  (full),
  .empty (empty)
);

// File: tb/tb_tsig_pipe_ctrl.sv
module tb_tsig_pipe_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int NB = 2;
  localparam int NVEC = 14;

  // Vector layout: [7] toggle up_req, [6] toggle dn_ack,
  // [5] expected up_ack, [4] expected dn_req, [3:0] expected occ.
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1_0_1_0_0001,  // token A enters (rising)
    8'b0_0_1_0_0010,  // A moves to stage 1
    8'b1_0_0_0_0101,  // token B enters (falling), A to stage 2
    8'b0_0_0_1_1010,  // A reaches the output
    8'b0_0_0_1_1100,  // B to stage 2
    8'b1_0_1_1_1101,  // token C enters
    8'b0_0_1_1_1110,
    8'b1_0_0_1_1111,  // token D: chain full
    8'b1_0_0_1_1111,  // token E waits: head locked
    8'b0_1_0_0_1011,  // consumer acknowledges
    8'b0_0_0_0_1101,
    8'b0_0_0_0_1110,
    8'b0_0_1_0_1111,  // release reaches head: E enters
    8'b0_1_1_1_1011   // consumer acknowledges again
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0, dn_ack = 1'b0;
  logic up_ack, dn_req, empty, full;
  logic [N-1:0] cap_en, occ;

  logic b_req = 1'b1, b_ack = 1'b1;
  logic b_up_ack, b_dn_req, b_empty, b_full;
  logic [NB-1:0] b_cap, b_occ;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsig_pipe_ctrl #(.N_STAGES(N), .INIT_LEVEL(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_ack(up_ack),
    .dn_req(dn_req), .dn_ack(dn_ack), .cap_en(cap_en), .occ(occ),
    .empty(empty), .full(full)
  );

  tsig_pipe_ctrl #(.N_STAGES(NB), .INIT_LEVEL(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .up_req(b_req), .up_ack(b_up_ack),
    .dn_req(b_dn_req), .dn_ack(b_ack), .cap_en(b_cap), .occ(b_occ),
    .empty(b_empty), .full(b_full)
  );

  task automatic chk(input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state of both instances
    chk("R1 up_ack", up_ack, 0);
    chk("R1 dn_req", dn_req, 0);
    chk("R1 occ", occ, 0);
    chk("R1 empty", empty, 1);
    chk("R1 full", full, 0);
    chk("R1 cap_en", cap_en, 0);
    chk("R1 b up_ack", b_up_ack, 1);
    chk("R1 b dn_req", b_dn_req, 1);
    chk("R1 b empty", b_empty, 1);
    rst_n = 1'b1;
    step();
    chk("R1 held after release", {up_ack, dn_req, occ}, 6'b0);

    // Table walk: R2, R3, R4, R5, R6, R8, R9, R10
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][7]) up_req = ~up_req;
      if (VEC[v][6]) dn_ack = ~dn_ack;
      step();
      chk($sformatf("R2/R4 up_ack vec%0d", v), up_ack, VEC[v][5]);
      chk($sformatf("R3 dn_req vec%0d", v), dn_req, VEC[v][4]);
      chk($sformatf("R8 occ vec%0d", v), occ, VEC[v][3:0]);
      chk($sformatf("R8 empty vec%0d", v), empty, (VEC[v][3:0] == 4'b0000));
      chk($sformatf("R9 full vec%0d", v), full, (VEC[v][3:0] == 4'b1111));
      chk($sformatf("R10 adjacent vec%0d", v), cap_en & (cap_en >> 1), 0);
      if (v == 8) chk("R5 head locked, up_ack kept", up_ack, 0);
      if (v == 12) chk("R6 waiting request proceeds", up_ack, 1);
    end

    // R1: reset in the middle of traffic
    rst_n = 1'b0;
    up_req = 1'b0;
    dn_ack = 1'b0;
    b_req = 1'b1;
    b_ack = 1'b1;
    #1;
    chk("R1 mid reset occ", occ, 0);
    chk("R1 mid reset up_ack", up_ack, 0);
    chk("R1 mid reset dn_req", dn_req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();

    // R7: capture enable precedes each stage toggle, one stage per cycle
    up_req = 1'b1;
    #1;
    chk("R7 cap_en before stage 0 edge", cap_en, 4'b0001);
    step();
    chk("R7 cap_en before stage 1 edge", cap_en, 4'b0010);
    chk("R4 up_ack after one edge", up_ack, 1);
    step();
    chk("R7 cap_en before stage 2 edge", cap_en, 4'b0100);
    step();
    chk("R7 cap_en before stage 3 edge", cap_en, 4'b1000);
    chk("R3 dn_req not yet", dn_req, 0);
    step();
    chk("R3 dn_req after N edges", dn_req, 1);
    chk("R7 cap_en quiet", cap_en, 4'b0000);

    // Second instance: falling first event, two stages
    b_req = 1'b0;
    step();
    chk("R4 b up_ack falls", b_up_ack, 0);
    chk("R3 b dn_req held", b_dn_req, 1);
    step();
    chk("R3 b dn_req falls", b_dn_req, 0);
    chk("R8 b occ", b_occ, 2'b10);
    chk("R8 b empty", b_empty, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule